// File: doc/BRIEF.md
# Cluster Private Window Decoder

This block sits in front of the 4 KB private peripheral window of a cluster of up to four CPUs. Each access arrives with the number of the CPU that issued it. The block decodes the low twelve address bits and sends the access to one of three places. The first is a snoop-control register group, which the block holds itself. The second is the port of a CPU interrupt interface. The third is a per-CPU timer/watchdog slot. Forwarded accesses leave the block with a target index and a local offset. The interrupt-interface and timer/watchdog logic sits outside this block.

Each forwarded group has alias windows. Its first 256-byte window always maps to the requesting CPU. The windows after it name a CPU explicitly. Inside a timer window, one address bit chooses between the timer and the watchdog of that CPU.

The block also routes timer and watchdog expiry events. Each event becomes a private interrupt on the CPU that owns the slot. The response to an access comes one clock after the request. It carries the read data and a one-cycle flag for an illegal offset.

Top module: `prv_win_decode`

## Requirements
- R1: Only `req_addr[11:0]` is decoded. Any value of the upper address bits gives the same forwarding, the same response and the same error flag.
- R2: Offset 0x000 is the snoop control register. It resets to 0, and a write stores only `wdata[0]`. A read returns that bit in bit 0, with bits 31:1 at zero.
- R3: Offset 0x004 reads as a configuration word. Bits 4+i are 1 for each present CPU i < NUM_CPU, and bits 1:0 hold NUM_CPU−1. All other bits are 0.
- R4: Offsets 0x008 and 0x00C read as zero. A write to 0x00C is accepted without error and changes nothing; a later read of 0x000 shows the control bit unchanged.
- R5: Offsets 0x100–0x1FF assert `gic_sel` with `gic_cpu` = `req_cpu` and `gic_off` = `addr[7:0]`.
- R6: Offsets 0x200–0x5FF assert `gic_sel` with `gic_cpu` = `addr[11:8]`−2 and `gic_off` = `addr[7:0]`.
- R7: Offsets 0x600–0x6FF assert `tmr_sel` for the requesting CPU. `tmr_slot` = 2·cpu + `addr[5]`, where bit 5 = 1 picks the watchdog and 0 picks the timer, and `tmr_off` = `addr[3:0]`.
- R8: Offsets 0x700–0xAFF assert `tmr_sel` for cpu = `addr[11:8]`−7, using the same slot and offset rule as R7.
- R9: If the resolved CPU in R5–R8 is not below NUM_CPU, neither select is asserted. The response reads zero and is not flagged as bad.
- R10: The following are illegal: a read of an offset below 0x100 other than 0x000/0x004/0x008/0x00C, a write of an offset below 0x100 other than 0x000/0x00C, and any offset at or above 0xB00. Such an access forwards nothing, and its response has `bad_access` = 1 for one cycle with zero read data.
- R11: A pulse on `tmr_fire[s]` for a slot whose CPU s/2 is below NUM_CPU sets bit 32·(s/2)+29 of `ppi_pend` one cycle later if s is even (timer), or bit 32·(s/2)+30 if s is odd (watchdog). All other bits are 0.
- R12: `rsp_valid` is high exactly one cycle after each `req_valid`. For a forwarded read, `rsp_rdata` holds the downstream read data sampled in the request cycle. Writes return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address (low 12 bits decoded) |
| req_wdata | input | DATA_W | Write data |
| req_cpu | input | 2 | Number of the requesting CPU |
| gic_sel | output | 1 | Access forwarded to an interrupt interface |
| gic_cpu | output | 2 | Target interrupt-interface CPU |
| gic_off | output | 8 | Local offset in the interrupt interface |
| gic_rdata | input | DATA_W | Read data from the interrupt interface (same cycle) |
| tmr_sel | output | 1 | Access forwarded to a timer/watchdog slot |
| tmr_slot | output | 3 | Slot index, 2·cpu + watchdog bit |
| tmr_off | output | 4 | Local offset in the slot |
| tmr_rdata | input | DATA_W | Read data from the slot (same cycle) |
| fwd_write | output | 1 | Write strobe qualifier for forwarded access |
| fwd_wdata | output | DATA_W | Write data for forwarded access |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | DATA_W | Response read data |
| bad_access | output | 1 | One-cycle illegal-offset flag |
| tmr_fire | input | 8 | Expiry events, one per slot |
| ppi_pend | output | 128 | Private interrupt set pulses, 32 per CPU |

## Verification
The bound assertions check several properties on every cycle. The response follows each request by exactly one cycle. The two forwarding selects never rise together. A forwarded CPU or slot never names an absent CPU. Every offset at or above 0xB00 raises the error flag, and a flagged response carries zero data. Reads of the control and configuration registers have the fixed bit layout. A timer event on slot 0 reaches interrupt 29 of CPU 0.

Other behaviour can only be shown by the bench's scenarios. These are the exact decode of every alias window for each requesting CPU, the dropping of accesses to an absent CPU, the write that has no effect, the independence from the upper address bits, and the full interrupt mapping of every slot.

// File: rtl/prv_win_pkg.sv
`timescale 1ns/1ps
package prv_win_pkg;
   localparam int MAXC     = 4;            // CPU windows the address map provides
   localparam int CPU_W    = 2;
   localparam int SLOT_N   = 2 * MAXC;
   localparam int SLOT_W   = 3;
   localparam int PPI_W    = 32;           // private interrupt lines per CPU
   localparam int TMR_PPI  = 29;
   localparam int WDG_PPI  = 30;
   localparam int OFS_W    = 12;

   localparam logic [OFS_W-1:0] SCU_CTRL = 12'h000;
   localparam logic [OFS_W-1:0] SCU_CFG  = 12'h004;
   localparam logic [OFS_W-1:0] SCU_STAT = 12'h008;
   localparam logic [OFS_W-1:0] SCU_INV  = 12'h00C;

   localparam logic [OFS_W-1:0] GIC_OWN  = 12'h100;
   localparam logic [OFS_W-1:0] GIC_EXP  = 12'h200;
   localparam logic [OFS_W-1:0] TMR_OWN  = 12'h600;
   localparam logic [OFS_W-1:0] TMR_EXP  = 12'h700;
   localparam logic [OFS_W-1:0] MAP_END  = 12'hB00;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_SCU,
      TGT_GIC,
      TGT_TMR,
      TGT_DROP,
      TGT_BAD
   } tgt_e;
endpackage

// File: rtl/prv_win_region.sv
`timescale 1ns/1ps
module prv_win_region
   import prv_win_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input  logic              valid,
   input  logic              write,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [CPU_W-1:0]  cpu,
   output tgt_e              kind,
   output logic [CPU_W-1:0]  tgt_cpu,
   output logic [SLOT_W-1:0] slot,
   output logic [7:0]        loc_ofs
);
   localparam logic [3:0] GIC_BASE_NIB = GIC_EXP[11:8];
   localparam logic [3:0] TMR_BASE_NIB = TMR_EXP[11:8];

   logic [3:0]       nib;
   logic [3:0]       gic_rel;
   logic [3:0]       tmr_rel;
   logic             scu_legal;
   logic [CPU_W-1:0] res_cpu;
   logic             cpu_ok;

   assign nib     = ofs[11:8];
   assign gic_rel = nib - GIC_BASE_NIB;
   assign tmr_rel = nib - TMR_BASE_NIB;

   always_comb begin
      if (write) scu_legal = (ofs == SCU_CTRL) || (ofs == SCU_INV);
      else       scu_legal = (ofs == SCU_CTRL) || (ofs == SCU_CFG) ||
                             (ofs == SCU_STAT) || (ofs == SCU_INV);
   end

   always_comb begin
      if (ofs < TMR_OWN) res_cpu = (ofs < GIC_EXP) ? cpu : gic_rel[CPU_W-1:0];
      else               res_cpu = (ofs < TMR_EXP) ? cpu : tmr_rel[CPU_W-1:0];
   end

   assign cpu_ok = ({1'b0, res_cpu} < (CPU_W+1)'(NUM_CPU));

   always_comb begin
      kind    = TGT_NONE;
      tgt_cpu = res_cpu;
      slot    = {res_cpu, ofs[5]};
      loc_ofs = 8'h00;
      if (valid) begin
         if (ofs < GIC_OWN) begin
            kind    = scu_legal ? TGT_SCU : TGT_BAD;
            loc_ofs = ofs[7:0];
         end else if (ofs < TMR_OWN) begin
            kind    = cpu_ok ? TGT_GIC : TGT_DROP;
            loc_ofs = ofs[7:0];
         end else if (ofs < MAP_END) begin
            kind    = cpu_ok ? TGT_TMR : TGT_DROP;
            loc_ofs = {4'h0, ofs[3:0]};
         end else begin
            kind    = TGT_BAD;
         end
      end
   end
endmodule

// File: rtl/prv_win_scu.sv
`timescale 1ns/1ps
module prv_win_scu
   import prv_win_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        ofs,
   input  logic              wbit,
   output logic [DATA_W-1:0] rdata
);
   logic             ctrl_q;
   logic [DATA_W-1:0] cfg_word;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_cfg
         if (i >= 4 && i < 4 + MAXC) begin : g_mask
            assign cfg_word[i] = ((i - 4) < NUM_CPU);
         end else if (i < CPU_W) begin : g_cnt
            assign cfg_word[i] = ((NUM_CPU - 1) >> i) & 1;
         end else begin : g_zero
            assign cfg_word[i] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= 1'b0;
      else if (wr_en) ctrl_q <= wbit;
   end

   always_comb begin
      unique case (ofs)
         SCU_CTRL[7:0]: rdata = {{(DATA_W-1){1'b0}}, ctrl_q};
         SCU_CFG[7:0]:  rdata = cfg_word;
         default:       rdata = '0;
      endcase
   end
endmodule

// File: rtl/prv_win_ppi.sv
`timescale 1ns/1ps
module prv_win_ppi
   import prv_win_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SLOT_N-1:0]     fire,
   output logic [MAXC*PPI_W-1:0] pend
);
   generate
      for (genvar c = 0; c < MAXC; c++) begin : g_cpu
         if (c < NUM_CPU) begin : g_live
            logic tmr_q, wdg_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  tmr_q <= 1'b0;
                  wdg_q <= 1'b0;
               end else begin
                  tmr_q <= fire[2*c];
                  wdg_q <= fire[2*c+1];
               end
            end
            always_comb begin
               pend[c*PPI_W +: PPI_W]          = '0;
               pend[c*PPI_W + TMR_PPI]          = tmr_q;
               pend[c*PPI_W + WDG_PPI]          = wdg_q;
            end
         end else begin : g_absent
            logic unused_fire;
            assign unused_fire = fire[2*c] ^ fire[2*c+1];
            assign pend[c*PPI_W +: PPI_W] = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/prv_win_decode.sv
`timescale 1ns/1ps
module prv_win_decode
   import prv_win_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [1:0]            req_cpu,
   output logic                  gic_sel,
   output logic [1:0]            gic_cpu,
   output logic [7:0]            gic_off,
   input  logic [DATA_W-1:0]     gic_rdata,
   output logic                  tmr_sel,
   output logic [2:0]            tmr_slot,
   output logic [3:0]            tmr_off,
   input  logic [DATA_W-1:0]     tmr_rdata,
   output logic                  fwd_write,
   output logic [DATA_W-1:0]     fwd_wdata,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic                  bad_access,
   input  logic [7:0]            tmr_fire,
   output logic [127:0]          ppi_pend
);
   initial begin
      if (NUM_CPU < 1 || NUM_CPU > MAXC)
         $error("prv_win_decode: NUM_CPU must lie in 1..%0d", MAXC);
      if (ADDR_W < OFS_W)
         $error("prv_win_decode: ADDR_W must cover the 12-bit window");
      if (DATA_W < 8)
         $error("prv_win_decode: DATA_W too narrow for configuration word");
   end

   tgt_e              kind;
   logic [CPU_W-1:0]  tgt_cpu;
   logic [SLOT_W-1:0] slot;
   logic [7:0]        loc_ofs;
   logic [DATA_W-1:0] scu_rdata;
   logic [DATA_W-1:0] rd_mux;
   logic              unused_addr_hi;

   assign unused_addr_hi = ^req_addr[ADDR_W-1:OFS_W];

   prv_win_region #(.NUM_CPU(NUM_CPU)) u_region (
      .valid   (req_valid),
      .write   (req_write),
      .ofs     (req_addr[OFS_W-1:0]),
      .cpu     (req_cpu),
      .kind    (kind),
      .tgt_cpu (tgt_cpu),
      .slot    (slot),
      .loc_ofs (loc_ofs)
   );

   prv_win_scu #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_scu (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (kind == TGT_SCU && req_write && loc_ofs == SCU_CTRL[7:0]),
      .ofs   (loc_ofs),
      .wbit  (req_wdata[0]),
      .rdata (scu_rdata)
   );

   prv_win_ppi #(.NUM_CPU(NUM_CPU)) u_ppi (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (tmr_fire),
      .pend  (ppi_pend)
   );

   assign gic_sel   = (kind == TGT_GIC);
   assign gic_cpu   = tgt_cpu;
   assign gic_off   = loc_ofs;
   assign tmr_sel   = (kind == TGT_TMR);
   assign tmr_slot  = slot;
   assign tmr_off   = loc_ofs[3:0];
   assign fwd_write = req_write;
   assign fwd_wdata = req_wdata;

   always_comb begin
      rd_mux = '0;
      if (!req_write) begin
         unique case (kind)
            TGT_SCU: rd_mux = scu_rdata;
            TGT_GIC: rd_mux = gic_rdata;
            TGT_TMR: rd_mux = tmr_rdata;
            default: rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         bad_access <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_rdata  <= rd_mux;
         bad_access <= (kind == TGT_BAD);
      end
   end
endmodule

// File: rtl/prv_win_decode_chk.sv
`timescale 1ns/1ps
module prv_win_decode_chk #(
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              gic_sel,
   input logic [1:0]        gic_cpu,
   input logic              tmr_sel,
   input logic [2:0]        tmr_slot,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              bad_access,
   input logic [7:0]        tmr_fire,
   input logic [127:0]      ppi_pend
);
   localparam logic [DATA_W-1:0] CFG_EXP =
      DATA_W'((((1 << NUM_CPU) - 1) << 4) | (NUM_CPU - 1));

   p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gic_sel, tmr_sel}));
   p_gic_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gic_sel |-> (32'(gic_cpu) < NUM_CPU));
   p_tmr_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_sel |-> (32'(tmr_slot) < 2 * NUM_CPU));
   p_high_bad_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[11:0] >= 12'hB00) |=> bad_access);
   p_bad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> (rsp_valid && rsp_rdata == '0));
   p_ctrl_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr[11:0] == 12'h000)
      |=> (rsp_rdata[DATA_W-1:1] == '0));
   p_cfg_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr[11:0] == 12'h004)
      |=> (rsp_rdata == CFG_EXP));
   p_timer_ppi_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_fire[0] |=> ppi_pend[29]);
endmodule

bind prv_win_decode prv_win_decode_chk #(
   .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/prv_win_decode_bench.sv
`timescale 1ns/1ps
module prv_win_decode_bench;
   localparam int NC = 3;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [31:0]   req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic [1:0]    req_cpu = '0;
   logic          gic_sel, tmr_sel, fwd_write, rsp_valid, bad_access;
   logic [1:0]    gic_cpu;
   logic [7:0]    gic_off;
   logic [2:0]    tmr_slot;
   logic [3:0]    tmr_off;
   logic [31:0]   gic_rdata, tmr_rdata, fwd_wdata, rsp_rdata;
   logic [7:0]    tmr_fire = '0;
   logic [127:0]  ppi_pend;

   int checks = 0;
   int failures = 0;
   logic ctrl_m = 1'b0;

   always #2.5 clk = ~clk;

   assign gic_rdata = 32'hC1C0_0000 | {22'h0, gic_cpu, gic_off};
   assign tmr_rdata = 32'h7A00_0000 | {25'h0, tmr_slot, tmr_off};

   prv_win_decode #(.NUM_CPU(NC)) u_prv_win_decode (.*);

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected model. kind: 0 none,1 scu,2 gic,3 tmr,4 drop,5 bad
   task automatic model(input logic [31:0] a, input bit wr, input logic [1:0] cpu,
                        output int kind, output int tcpu, output int slot,
                        output int lofs, output logic [31:0] rd);
      int o = int'(a[11:0]);
      kind = 0; tcpu = 0; slot = 0; lofs = 0; rd = '0;
      if (o < 'h100) begin
         bit legal = wr ? (o == 0 || o == 'hC)
                        : (o == 0 || o == 4 || o == 8 || o == 'hC);
         kind = legal ? 1 : 5;
         if (legal && !wr) rd = (o == 0) ? {31'h0, ctrl_m} :
                                (o == 4) ? 32'h0000_0072 : 32'h0;
      end else if (o < 'h600) begin
         tcpu = (o < 'h200) ? int'(cpu) : (o - 'h200) >> 8;
         lofs = o & 'hFF;
         kind = (tcpu < NC) ? 2 : 4;
         if (kind == 2 && !wr) rd = 32'hC1C0_0000 | 32'(tcpu << 8) | 32'(lofs);
      end else if (o < 'hB00) begin
         tcpu = (o < 'h700) ? int'(cpu) : (o - 'h700) >> 8;
         slot = tcpu * 2 + ((o >> 5) & 1);
         lofs = o & 'hF;
         kind = (tcpu < NC) ? 3 : 4;
         if (kind == 3 && !wr) rd = 32'h7A00_0000 | 32'(slot << 4) | 32'(lofs);
      end else begin
         kind = 5;
      end
   endtask

   task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] d,
                         input logic [1:0] cpu);
      int kind, tcpu, slot, lofs;
      logic [31:0] rd;
      model(a, wr, cpu, kind, tcpu, slot, lofs, rd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_cpu = cpu;
      #1;
      check(gic_sel == (kind == 2), "R5/R6/R9 gic_sel", gic_sel, kind == 2);
      check(tmr_sel == (kind == 3), "R7/R8/R9 tmr_sel", tmr_sel, kind == 3);
      if (kind == 2) begin
         check(gic_cpu == tcpu[1:0] && gic_off == lofs[7:0], "R5 R6 gic target",
               {gic_cpu, gic_off}, {tcpu[1:0], lofs[7:0]});
      end
      if (kind == 3) begin
         check(tmr_slot == slot[2:0] && tmr_off == lofs[3:0], "R7 R8 tmr target",
               {tmr_slot, tmr_off}, {slot[2:0], lofs[3:0]});
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      check(rsp_valid === 1'b1, "R12 rsp_valid", rsp_valid, 1);
      check(bad_access === (kind == 5), "R10 bad_access", bad_access, kind == 5);
      check(rsp_rdata === rd, "R1/R2/R3/R4/R12 rsp_rdata", rsp_rdata, rd);
      if (kind == 1 && wr && a[11:0] == 12'h000) ctrl_m = d[0];
   endtask

   task automatic fire(input logic [7:0] f);
      logic [127:0] exp = '0;
      for (int s = 0; s < 2 * NC; s++)
         if (f[s]) exp[(s / 2) * 32 + 29 + (s % 2)] = 1'b1;
      @(negedge clk);
      tmr_fire = f;
      @(posedge clk);
      #1;
      tmr_fire = '0;
      check(ppi_pend === exp, "R11 ppi_pend", ppi_pend, exp);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      check(rsp_valid === 1'b0 && bad_access === 1'b0 && ppi_pend === '0,
            "reset outputs", {rsp_valid, bad_access}, 0);
      rst_n = 1'b1;
      // R2 reset value, store bit 0 only
      access(32'h0000_0000, 0, 0, 0);
      access(32'h0000_0000, 1, 32'hFFFF_FFFE, 1);
      access(32'h0000_0000, 0, 0, 0);
      access(32'h0000_0000, 1, 32'hFFFF_FFFF, 2);
      access(32'h0000_0000, 0, 0, 0);
      // R3 config, R1 upper bits ignored
      access(32'h0000_0004, 0, 0, 0);
      access(32'hFFFF_F004, 0, 0, 1);
      // R4 zero reads, no-effect write
      access(32'h0000_0008, 0, 0, 0);
      access(32'h0000_000C, 1, 32'h0, 0);
      access(32'h0000_000C, 0, 0, 0);
      access(32'h0000_0000, 0, 0, 0);
      // R10 illegal scu offsets and writes, top of map
      access(32'h0000_0004, 1, 32'h1, 0);
      access(32'h0000_0008, 1, 32'h1, 0);
      access(32'h0000_0010, 0, 0, 0);
      access(32'h0000_0001, 0, 0, 0);
      access(32'h0000_0B00, 0, 0, 0);
      access(32'h0000_0FFC, 1, 32'h5, 0);
      access(32'h0000_0000, 0, 0, 0);
      // R5..R9 window edges
      access(32'h0000_0100, 0, 0, 2);
      access(32'h0000_01FF, 0, 0, 3);
      access(32'h0000_0200, 0, 0, 0);
      access(32'h0000_04FC, 0, 0, 0);
      access(32'h0000_0500, 0, 0, 0);
      access(32'h0000_0600, 0, 0, 1);
      access(32'h0000_0620, 0, 0, 2);
      access(32'h0000_06FF, 0, 0, 3);
      access(32'h0000_0724, 0, 0, 0);
      access(32'h0000_0928, 1, 32'h9, 0);
      access(32'h0000_0A20, 0, 0, 0);
      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a = $urandom();
         if (i % 4 == 0) a[11:0] = {8'h00, $urandom_range(0, 15)[3:0]};
         access(a, $urandom_range(0, 1) == 1, $urandom(), 2'($urandom_range(0, 3)));
      end
      // R11 interrupt routing
      fire(8'h01);
      fire(8'h02);
      fire(8'h30);
      fire(8'hC0);
      fire(8'h00);
      for (int i = 0; i < 20; i++) fire(8'($urandom()));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule